// File: doc/BRIEF.md
# I2C Master Write Controller

This block is the transmit side of a two-wire master. A pulse on `go` starts a transfer. The block then sends a START condition and the 7-bit device address with the write bit cleared. Next come zero to three internal address bytes, and after those the data bytes, which it takes one at a time from a single-entry holding register. After every byte it releases SDA for the acknowledge pulse and samples the receiver's answer.

Software or a DMA channel refills the holding register whenever `txrdy` is high, so `txrdy` also serves as the DMA request. If the register is still empty when a byte has been acknowledged, the block ends the transfer with a STOP without being told to. A missing acknowledge also ends the transfer with a STOP. The pads are open-drain: each output-enable pulls its line low, and the SDA level comes back on a separate input.

Top module: `i2c_wr_master`

## Requirements
- R1: After `go` in the idle state, the block sends one START: SDA falls while SCL is high. The first byte on the bus is `{dev_addr, 1'b0}`, most significant bit first.
- R2: After the address byte, `iadr_len` (0 to 3) internal address bytes follow, most significant byte first. With a length of 3 they are `iadr[23:16]`, `iadr[15:8]`, `iadr[7:0]`; shorter lengths send only the lower bytes, in the same order.
- R3: SDA is released during the ninth (acknowledge) clock pulse of every byte. The level read on `sda_in` at the end of that pulse is the acknowledge, where low means ACK.
- R4: A high acknowledge sets `nack`, which stays set until the next accepted `go`. The block sends no further byte after it, issues a STOP and sets `txcomp`. A byte still waiting in the holding register is not consumed, so `txrdy` stays low.
- R5: `txrdy` falls on the cycle after a `thr_we` write. It rises when the held byte moves into the shifter after an ACK, and it stays high until the next write. The held bytes are sent in the order they were written.
- R6: When a byte is acknowledged, no internal address byte remains and the holding register is empty, the block sends exactly one STOP: SDA rises while SCL is high. It sends no further byte.
- R7: `txcomp` is 1 out of reset, falls on the cycle after an accepted `go`, and rises once the STOP is complete. While it is set, both pads are released.
- R8: `irq` is the OR of the status flags gated by `ien`. Bit 2 of `ien` enables `nack`, bit 1 enables `txrdy` and bit 0 enables `txcomp`.
- R9: Every SCL low period of a transfer lasts `scl_lo`+1 clock cycles. Every SCL high period that ends in a falling edge, apart from the START hold, lasts `scl_hi`+1 cycles.
- R10: SDA changes while SCL is high only for the one START and the one STOP of each transfer.
- R11: A `go` pulse while a transfer is in progress is ignored. The transfer's bytes and its single START are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start a transfer (accepted only when idle) |
| dev_addr | input | 7 | Device address |
| iadr_len | input | 2 | Number of internal address bytes, 0 to 3 |
| iadr | input | 24 | Internal address value |
| scl_lo | input | CW | SCL low count (period is value+1 cycles, value at least 1) |
| scl_hi | input | CW | SCL high count (period is value+1 cycles, value at least 1) |
| thr_we | input | 1 | Write strobe of the holding register |
| thr_data | input | 8 | Data written to the holding register |
| ien | input | 3 | Interrupt enables {nack, txrdy, txcomp} |
| irq | output | 1 | Interrupt request |
| nack | output | 1 | Sticky missing-acknowledge flag |
| txrdy | output | 1 | Holding register empty, also the DMA request |
| txcomp | output | 1 | Transfer complete |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA level |

## Verification
The assertions assume that `scl_lo` and `scl_hi` are at least 1 and that the configuration inputs do not change while a transfer runs. They also assume that only the receiver drives SDA low, and only during the acknowledge pulse. The bench sets the dividers and the address fields before each `go` and leaves them unchanged until `txcomp` returns. Its receiver model pulls SDA only between the eighth and ninth falling edges of SCL. It writes the holding register only while `txrdy` is high, except for the single preload made before `go`.

// File: rtl/i2c_wr_master.sv
module i2c_wr_master #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [6:0]    dev_addr,
  input  logic [1:0]    iadr_len,
  input  logic [23:0]   iadr,
  input  logic [CW-1:0] scl_lo,
  input  logic [CW-1:0] scl_hi,
  input  logic          thr_we,
  input  logic [7:0]    thr_data,
  input  logic [2:0]    ien,
  output logic          irq,
  output logic          nack,
  output logic          txrdy,
  output logic          txcomp,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          sda_in
);
  localparam logic [3:0] ACK_BIT = 4'd8;

  typedef enum logic [1:0] {IDLE, STA, XFER, STO} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic          ph;
  logic [3:0]    bitn;
  logic [7:0]    sh, thr;
  logic          thr_full;
  logic [1:0]    ileft;
  logic          pend;

  wire       tick  = (cnt == '0);
  wire [1:0] isel  = ileft - 2'd1;
  wire [7:0] ibyte = (isel == 2'd2) ? iadr[23:16] :
                     (isel == 2'd1) ? iadr[15:8]  : iadr[7:0];

  assign txrdy = !thr_full;
  assign irq   = |({nack, txrdy, txcomp} & ien);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; ph <= 1'b0; bitn <= '0; sh <= '0; thr <= '0;
      thr_full <= 1'b0; ileft <= '0; pend <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0; nack <= 1'b0; txcomp <= 1'b1;
    end else begin
      if (st != IDLE && !tick) cnt <= cnt - 1'b1;
      pend <= 1'b0;
      case (st)
        IDLE: if (go) begin
          st <= STA; cnt <= scl_hi; sda_oe <= 1'b1;
          nack <= 1'b0; txcomp <= 1'b0;
          sh <= {dev_addr, 1'b0}; ileft <= iadr_len;
        end
        STA: if (tick) begin
          st <= XFER; scl_oe <= 1'b1; ph <= 1'b0; bitn <= '0;
          cnt <= scl_lo; pend <= 1'b1;
        end
        XFER: begin
          if (pend) sda_oe <= (bitn == ACK_BIT) ? 1'b0 : !sh[7];
          if (tick) begin
            if (!ph) begin
              scl_oe <= 1'b0; ph <= 1'b1; cnt <= scl_hi;
            end else if (bitn != ACK_BIT) begin
              sh <= {sh[6:0], 1'b0}; bitn <= bitn + 1'b1;
              scl_oe <= 1'b1; ph <= 1'b0; cnt <= scl_lo; pend <= 1'b1;
            end else begin
              scl_oe <= 1'b1; ph <= 1'b0; cnt <= scl_lo; pend <= 1'b1; bitn <= '0;
              if (sda_in) begin
                nack <= 1'b1; st <= STO;
              end else if (ileft != 2'd0) begin
                sh <= ibyte; ileft <= ileft - 2'd1;
              end else if (thr_full) begin
                sh <= thr; thr_full <= 1'b0;
              end else begin
                st <= STO;
              end
            end
          end
        end
        STO: begin
          if (pend) sda_oe <= 1'b1;
          if (tick) begin
            if (!ph) begin
              scl_oe <= 1'b0; ph <= 1'b1; cnt <= scl_hi; bitn <= '0;
            end else if (bitn == '0) begin
              sda_oe <= 1'b0; bitn <= 4'd1; cnt <= scl_hi;
            end else begin
              st <= IDLE; txcomp <= 1'b1;
            end
          end
        end
        default: st <= IDLE;
      endcase
      if (thr_we) begin
        thr <= thr_data; thr_full <= 1'b1;
      end
    end
  end

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == XFER && ph && bitn == ACK_BIT) |-> !sda_oe); // R3

  AST_SDA_QUIET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == XFER && ph && $past(st == XFER && ph)) |-> $stable(sda_oe)); // R10

  AST_NACK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(nack) && $past(st) != IDLE) |-> nack); // R4

  AST_TXRDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(txrdy) && !$past(thr_we)) |-> txrdy); // R5

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    txcomp |-> (!scl_oe && !sda_oe)); // R7
endmodule

// File: tb/tb_i2c_wr_master.sv
module tb_i2c_wr_master;
  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, thr_we = 1'b0;
  logic [6:0] dev_addr = '0;
  logic [1:0] iadr_len = '0;
  logic [23:0] iadr = '0;
  logic [7:0] scl_lo = 8'd1, scl_hi = 8'd1, thr_data = '0;
  logic [2:0] ien = '0;
  logic irq, nack, txrdy, txcomp, scl_oe, sda_oe, sda_in;

  i2c_wr_master dut (.clk(clk), .rst_n(rst_n), .go(go), .dev_addr(dev_addr),
    .iadr_len(iadr_len), .iadr(iadr), .scl_lo(scl_lo), .scl_hi(scl_hi),
    .thr_we(thr_we), .thr_data(thr_data), .ien(ien), .irq(irq), .nack(nack),
    .txrdy(txrdy), .txcomp(txcomp), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, total = 0;
  logic pull = 1'b0;
  wire scl_w = !scl_oe;
  wire sda_w = !(sda_oe || pull);
  assign sda_in = sda_w;

  int starts, stops, nrx, bitcnt, run, bad_lo, bad_hi, ack_err, nack_at, cur_lo, cur_hi;
  logic pscl = 1'b1, psda = 1'b1, first_fall = 1'b0;
  logic [7:0] sr;
  logic [7:0] rx [0:15];
  logic stale_valid = 1'b0;
  logic [7:0] stale_val = '0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic s;
    s = sda_w;
    if (scl_w && pscl && psda && !s) begin starts++; bitcnt = 0; first_fall = 1'b1; end
    if (scl_w && pscl && !psda && s) begin stops++; bitcnt = 0; end
    if (scl_w != pscl) begin
      if (starts > 0) begin
        if (!pscl && run != cur_lo + 1) bad_lo++;
        if (pscl && !first_fall && run != cur_hi + 1) bad_hi++;
      end
      if (pscl) first_fall = 1'b0;
      run = 1;
    end else run++;
    if (scl_w && !pscl) begin
      if (bitcnt < 8) begin
        sr = {sr[6:0], s}; bitcnt++;
        if (bitcnt == 8) begin if (nrx < 16) rx[nrx] = sr; nrx++; end
      end else if (bitcnt == 8) begin
        if (!pull && !s) ack_err++;
        bitcnt = 9;
      end
    end
    if (!scl_w && pscl) begin
      if (bitcnt == 8) pull = ((nrx - 1) != nack_at);
      else if (bitcnt == 9) begin pull = 1'b0; bitcnt = 0; end
    end
    pscl = scl_w; psda = s;
  end

  always @(posedge clk) begin
    total++;
    if (total > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", total, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic run_xfer(input int lo, input int hi, input int il, input int nd_in,
                          input int nk, input bit busy_go);
    logic [7:0] exp [0:15];
    logic [7:0] d [0:3];
    int nd, fed, cyc, nexp;
    bit pre_stale;
    nd = nd_in;
    pre_stale = stale_valid;
    if (pre_stale && nd == 0) nd = 1;
    for (int k = 0; k < 4; k++) d[k] = 8'(k * 53 + lo * 7 + hi * 3 + il) ^ 8'h96;
    if (pre_stale) d[0] = stale_val;
    scl_lo = 8'(lo); scl_hi = 8'(hi); cur_lo = lo; cur_hi = hi;
    iadr_len = 2'(il); iadr = 24'hC3A51E ^ 24'(lo << 4 | hi << 12);
    dev_addr = 7'(lo * 29 + hi * 11 + il * 5 + nd);
    starts = 0; stops = 0; nrx = 0; bitcnt = 0; run = 0; bad_lo = 0; bad_hi = 0;
    ack_err = 0; nack_at = nk;
    exp[0] = {dev_addr, 1'b0};
    for (int k = 0; k < il; k++) exp[1 + k] = 8'(iadr >> (8 * (il - 1 - k)));
    for (int k = 0; k < nd; k++) exp[1 + il + k] = d[k];
    nexp = (nk >= 0) ? nk + 1 : 1 + il + nd;
    fed = 0;
    if (nd > 0 && !pre_stale) begin
      @(negedge clk); thr_we = 1'b1; thr_data = d[0];
      @(negedge clk); thr_we = 1'b0;
      chk(txrdy == 1'b0, "R5 txrdy low after write", txrdy, 0);
    end
    if (nd > 0) fed = 1;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    chk(txcomp == 1'b0, "R7 txcomp cleared by go", txcomp, 0);
    cyc = 0;
    forever begin
      @(negedge clk);
      thr_we = 1'b0; go = 1'b0; cyc++;
      if (busy_go && cyc == 40) go = 1'b1;
      if (txcomp) break;
      if (fed < nd && txrdy) begin thr_we = 1'b1; thr_data = d[fed]; fed++; end
    end
    chk(nrx == nexp, "R6 byte count before STOP", nrx, nexp);
    if (nrx > 0) chk(rx[0] == exp[0], "R1 address byte", rx[0], exp[0]);
    for (int k = 1; k < nexp && k < nrx; k++) begin
      if (k <= il) chk(rx[k] == exp[k], "R2 internal address byte", rx[k], exp[k]);
      else chk(rx[k] == exp[k], "R5 data byte order", rx[k], exp[k]);
    end
    chk(starts == 1, busy_go ? "R11 single START" : "R1 single START", starts, 1);
    chk(stops == 1 && starts == 1, "R10 only START and STOP with SCL high", stops, 1);
    chk(bad_lo == 0, "R9 SCL low period", bad_lo, 0);
    chk(bad_hi == 0, "R9 SCL high period", bad_hi, 0);
    chk(ack_err == 0, "R3 SDA released in ack pulse", ack_err, 0);
    chk(nack == (nk >= 0), "R4 nack flag", nack, nk >= 0);
    chk(txrdy == !(nk >= 0 && nd > 0), "R4 txrdy after transfer", txrdy, !(nk >= 0 && nd > 0));
    chk(txcomp == 1'b1 && !scl_oe && !sda_oe, "R7 txcomp and bus released", txcomp, 1);
    stale_valid = (nk >= 0 && nd > 0);
    stale_val = d[0];
  endtask

  task automatic irq_sweep(input bit nk_flag, input bit rdy_flag);
    for (int m = 0; m < 8; m++) begin
      @(negedge clk); ien = 3'(m);
      #1;
      chk(irq == |(3'(m) & {nk_flag, rdy_flag, 1'b1}), "R8 interrupt mask", irq,
          |(3'(m) & {nk_flag, rdy_flag, 1'b1}));
    end
    ien = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txcomp == 1'b1, "R7 reset txcomp", txcomp, 1);
    chk(txrdy == 1'b1, "R5 reset txrdy", txrdy, 1);
    chk(nack == 1'b0, "R4 reset nack", nack, 0);
    chk(!scl_oe && !sda_oe, "R7 reset pads released", scl_oe, 0);
    chk(irq == 1'b0, "R8 reset irq masked", irq, 0);
    for (int lo = 1; lo <= 3; lo++)
      for (int hi = 1; hi <= 2; hi++)
        for (int il = 0; il <= 3; il++)
          for (int nd = 0; nd <= 2; nd++)
            run_xfer(lo, hi, il, nd, -1, 1'b0);
    irq_sweep(1'b0, 1'b1);
    run_xfer(2, 1, 1, 3, -1, 1'b1);
    for (int il = 0; il <= 2; il++)
      for (int nk = 0; nk <= il; nk++) begin
        run_xfer(1, 2, il, 1, nk, 1'b0);
        if (il == 2 && nk == 2) irq_sweep(1'b1, 1'b0);
        run_xfer(2, 2, il, 2, -1, 1'b0);
        chk(nack == 1'b0, "R4 nack cleared by next go", nack, 0);
      end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule